// File: doc/BRIEF.md
# Multichannel SPI DAC Command Controller

This block sits between on-chip logic and an external serial DAC that has two or four outputs and 8, 10 or 12 bits of resolution. Requests arrive through a valid/ready handshake and are of three kinds:

- a channel write,
- a sleep/wake request,
- a selection of the sleep termination.

The block keeps its own copy of every channel value, the sleep flag and the chosen termination. It sends a 16-bit frame to the converter only when a request really changes the device state. Each request ends with a one-cycle pulse:

- done when it took effect or had nothing to do,
- error when it was illegal,
- busy when it was refused because the device is asleep.

Frames go out MSB first in SPI mode 0. Chip select stays low for exactly one frame. The serial clock runs at the system clock divided by 2*HALF_DIV. Right after reset the block loads zero into all outputs with a single broadcast frame, and it accepts no request until that frame is out. The stored channel values and the sleep flag change only once the frame that carries the change has fully left the shifter. This keeps the stored state equal to what the device holds.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Every frame is 16 bits, MSB first, with `sclk_o` low while `cs_no` is high. Data is stable on each rising edge of `sclk_o`, and `cs_no` stays low for exactly 16 rising edges. Frame bits 15:14 hold the channel (or termination code), bits 13:12 the opcode (00 load without update, 01 load and update, 10 load and update all, 11 sleep), and bits 11:0 the data field.
- R2: A channel value sits left-aligned in the 12-bit data field. It is shifted left by 12-RES, and the low bits are zero.
- R3: After reset the block sends exactly one frame 0x2000 with `req_ready_o` held low, then raises `req_ready_o`. At that point `pd_o` is 0 and every stored channel value is 0.
- R4: The block answers `err_o` and sends no frame in three cases: a write (`req_op_i`=0) whose value is at or above 2^RES, a write to a channel at or above NUM_CH, and `req_op_i`=3. The stored values stay unchanged.
- R5: A write whose value equals the stored value of that channel answers `done_o` without a frame, even while asleep.
- R6: A write that would change a channel while `pd_o` is 1 answers `busy_o` and sends no frame.
- R7: Any other legal write sends {channel, 01, data}, then updates the stored value on `cache_o` and answers `done_o`.
- R8: A sleep request (`req_op_i`=1, `req_val_i[0]`=1) while awake sends {termination+1, 11, 0}, then sets `pd_o` and answers `done_o`. A sleep or wake request that matches the current state answers `done_o` without a frame.
- R9: A wake request (`req_op_i`=1, `req_val_i[0]`=0) while asleep sends {00, 01, stored channel 0 value}, then clears `pd_o`.
- R10: A termination select (`req_op_i`=2, code in `req_val_i[1:0]`: 0 = 2.5 kOhm, 1 = 100 kOhm, 2 = high impedance, 3 = error) behaves as follows:
  - while asleep with a new code, it sends a sleep frame carrying that code;
  - while awake, it only records the code, which the next sleep frame carries;
  - if the code is the current one, it answers `done_o` with no frame.
- R11: `req_ready_o` is low from the acceptance of a request that sends a frame until its response. Each accepted request gets exactly one one-cycle pulse on one of `done_o`, `err_o`, `busy_o`.
- R12: `cs_no` is low for 32*HALF_DIV clock cycles per frame, and it stays high for at least 2*HALF_DIV cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_op_i | input | 2 | 0 write, 1 sleep/wake, 2 termination select, 3 reserved |
| req_ch_i | input | 2 | Channel for a write |
| req_val_i | input | 12 | Write value, sleep bit in [0], or termination code in [1:0] |
| done_o | output | 1 | Request completed (pulse) |
| err_o | output | 1 | Request illegal (pulse) |
| busy_o | output | 1 | Write refused while asleep (pulse) |
| pd_o | output | 1 | Device is asleep |
| cache_o | output | NUM_CH*RES | Stored channel values, channel i at [i*RES +: RES] |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the converter |

## Verification
The directed tests drive writes with values that differ from the stored copy, equal it, and exceed the range:
- the differing values give a frame and a stored update;
- the equal values give done without a frame;
- the out-of-range values give an error and leave state unchanged.

Writes are repeated while asleep to separate the busy refusal from the redundant-write shortcut, which takes precedence. Termination selects are issued both asleep and awake, and the code is then observed inside a later sleep frame, which separates immediate transmission from silent recording. Wake frames are decoded to show that they carry the stored channel 0 value rather than the last value written.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int FRAME_W = 16;
  localparam int FIELD_W = 12;

  typedef enum logic [1:0] {
    OPC_LOAD     = 2'b00,
    OPC_LOAD_UPD = 2'b01,
    OPC_LOAD_ALL = 2'b10,
    OPC_SLEEP    = 2'b11
  } dac_opc_e;

  typedef enum logic [1:0] {
    REQ_WRITE = 2'd0,
    REQ_POWER = 2'd1,
    REQ_TERM  = 2'd2,
    REQ_RSVD  = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_IDLE,
    ST_XFER
  } ctrl_state_e;
endpackage

// File: rtl/dac_frame_fmt.sv
module dac_frame_fmt
  import dac_cmd_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic [1:0]         addr_i,
  input  dac_opc_e           opc_i,
  input  logic [RES-1:0]     val_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int PAD = FIELD_W - RES;

  generate
    if (PAD == 0) begin : g_full
      assign frame_o = {addr_i, opc_i, val_i};
    end else begin : g_pad
      assign frame_o = {addr_i, opc_i, val_i, {PAD{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/dac_spi_tx.sv
module dac_spi_tx
  import dac_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               done_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  logic               active_q, gap_q, gap_half_q, sclk_q, cs_n_q, done_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_W-1:0]   bit_q;
  logic [DIV_W-1:0]   div_q;
  logic               tick;

  assign tick = (div_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      gap_q      <= 1'b0;
      gap_half_q <= 1'b0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      sh_q       <= '0;
      bit_q      <= '0;
      div_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q   <= 1'b1;
          cs_n_q     <= 1'b0;
          sh_q       <= frame_i;
          sclk_q     <= 1'b0;
          div_q      <= '0;
          bit_q      <= '0;
          gap_q      <= 1'b0;
          gap_half_q <= 1'b0;
        end
      end else if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (gap_q) begin
          // chip select idles one full serial clock period
          if (gap_half_q) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            gap_half_q <= 1'b1;
          end
        end else if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == BIT_W'(FRAME_W - 1)) begin
            cs_n_q <= 1'b1;
            gap_q  <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign sclk_o = sclk_q;
  assign cs_no  = cs_n_q;
  assign mosi_o = sh_q[FRAME_W-1];
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES      = 10,
  parameter int HALF_DIV = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [1:0]            req_op_i,
  input  logic [1:0]            req_ch_i,
  input  logic [11:0]           req_val_i,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  busy_o,
  output logic                  pd_o,
  output logic [NUM_CH*RES-1:0] cache_o,
  output logic                  sclk_o,
  output logic                  cs_no,
  output logic                  mosi_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  ctrl_state_e        state_q;
  logic [RES-1:0]     cache_q [NUM_CH];
  logic               pd_q;
  logic [1:0]         term_q;
  logic               launch_q, silent_q;
  logic [FRAME_W-1:0] frame_q;
  logic               done_q, err_q, busy_q;
  logic               upd_cache_q, upd_pd_q, upd_term_q;
  logic [CH_W-1:0]    upd_ch_q;
  logic [RES-1:0]     upd_val_q;
  logic               upd_pd_val_q;
  logic [1:0]         upd_term_val_q;

  logic [1:0]         fmt_addr;
  dac_opc_e           fmt_opc;
  logic [RES-1:0]     fmt_val;
  logic [FRAME_W-1:0] fmt_frame;
  logic               tx_done;
  logic [CH_W-1:0]    ch_idx;
  logic               ch_oor, val_oor, val_same;

  assign ch_idx   = req_ch_i[CH_W-1:0];
  assign ch_oor   = (32'(req_ch_i) >= NUM_CH);
  assign val_oor  = (RES < FIELD_W) ? ((req_val_i >> RES) != '0) : 1'b0;
  assign val_same = (req_val_i[RES-1:0] == cache_q[ch_idx]);

  always_comb begin
    fmt_addr = 2'b00;
    fmt_opc  = OPC_LOAD_ALL;
    fmt_val  = '0;
    if (state_q == ST_IDLE) begin
      unique case (req_op_e'(req_op_i))
        REQ_WRITE: begin
          fmt_addr = req_ch_i;
          fmt_opc  = OPC_LOAD_UPD;
          fmt_val  = req_val_i[RES-1:0];
        end
        REQ_POWER: begin
          if (req_val_i[0]) begin
            fmt_addr = term_q + 2'd1;
            fmt_opc  = OPC_SLEEP;
          end else begin
            fmt_opc = OPC_LOAD_UPD;
            fmt_val = cache_q[0];
          end
        end
        REQ_TERM: begin
          fmt_addr = req_val_i[1:0] + 2'd1;
          fmt_opc  = OPC_SLEEP;
        end
        default: ;
      endcase
    end
  end

  dac_frame_fmt #(.RES(RES)) u_fmt (
    .addr_i (fmt_addr),
    .opc_i  (fmt_opc),
    .val_i  (fmt_val),
    .frame_o(fmt_frame)
  );

  dac_spi_tx #(.HALF_DIV(HALF_DIV)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(launch_q),
    .frame_i(frame_q),
    .done_o (tx_done),
    .sclk_o (sclk_o),
    .cs_no  (cs_no),
    .mosi_o (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_BOOT;
      for (int i = 0; i < NUM_CH; i++) cache_q[i] <= '0;
      pd_q           <= 1'b0;
      term_q         <= 2'd0;
      launch_q       <= 1'b0;
      silent_q       <= 1'b0;
      frame_q        <= '0;
      done_q         <= 1'b0;
      err_q          <= 1'b0;
      busy_q         <= 1'b0;
      upd_cache_q    <= 1'b0;
      upd_pd_q       <= 1'b0;
      upd_term_q     <= 1'b0;
      upd_ch_q       <= '0;
      upd_val_q      <= '0;
      upd_pd_val_q   <= 1'b0;
      upd_term_val_q <= 2'd0;
    end else begin
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      busy_q   <= 1'b0;
      unique case (state_q)
        ST_BOOT: begin
          frame_q     <= fmt_frame;
          launch_q    <= 1'b1;
          silent_q    <= 1'b1;
          upd_cache_q <= 1'b0;
          upd_pd_q    <= 1'b0;
          upd_term_q  <= 1'b0;
          state_q     <= ST_XFER;
        end
        ST_IDLE: begin
          if (req_valid_i) begin
            frame_q     <= fmt_frame;
            silent_q    <= 1'b0;
            upd_cache_q <= 1'b0;
            upd_pd_q    <= 1'b0;
            upd_term_q  <= 1'b0;
            unique case (req_op_e'(req_op_i))
              REQ_WRITE: begin
                if (ch_oor || val_oor) err_q <= 1'b1;
                else if (val_same) done_q <= 1'b1;
                else if (pd_q) busy_q <= 1'b1;
                else begin
                  launch_q    <= 1'b1;
                  upd_cache_q <= 1'b1;
                  upd_ch_q    <= ch_idx;
                  upd_val_q   <= req_val_i[RES-1:0];
                  state_q     <= ST_XFER;
                end
              end
              REQ_POWER: begin
                if (req_val_i[0] == pd_q) done_q <= 1'b1;
                else begin
                  launch_q     <= 1'b1;
                  upd_pd_q     <= 1'b1;
                  upd_pd_val_q <= req_val_i[0];
                  state_q      <= ST_XFER;
                end
              end
              REQ_TERM: begin
                if (req_val_i[1:0] == 2'd3) err_q <= 1'b1;
                else if (req_val_i[1:0] == term_q) done_q <= 1'b1;
                else if (pd_q) begin
                  launch_q       <= 1'b1;
                  upd_term_q     <= 1'b1;
                  upd_term_val_q <= req_val_i[1:0];
                  state_q        <= ST_XFER;
                end else begin
                  term_q <= req_val_i[1:0];
                  done_q <= 1'b1;
                end
              end
              default: err_q <= 1'b1;
            endcase
          end
        end
        ST_XFER: begin
          if (tx_done) begin
            if (upd_cache_q) cache_q[upd_ch_q] <= upd_val_q;
            if (upd_pd_q)    pd_q <= upd_pd_val_q;
            if (upd_term_q)  term_q <= upd_term_val_q;
            done_q  <= !silent_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cache
      assign cache_o[g*RES +: RES] = cache_q[g];
    end
  endgenerate

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign busy_o      = busy_q;
  assign pd_o        = pd_q;
endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk #(
  parameter int NUM_CH   = 4,
  parameter int RES      = 10,
  parameter int HALF_DIV = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic                  done_o,
  input logic                  err_o,
  input logic                  busy_o,
  input logic                  pd_o,
  input logic [NUM_CH*RES-1:0] cache_o,
  input logic                  sclk_o,
  input logic                  cs_no
);
  logic        sclk_d;
  logic [5:0]  rise_cnt;
  logic [15:0] hi_cnt;
  logic        seen_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d     <= 1'b0;
      rise_cnt   <= '0;
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_no) rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_no) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      if (!cs_no) seen_frame <= 1'b1;
    end
  end

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_frame_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> rise_cnt == 6'd16);
  p_sclk_in_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> $past(!cs_no));
  p_gap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_frame) |-> hi_cnt >= 16'(2 * HALF_DIV));
  p_err_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cs_no);
  p_busy_asleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pd_o && cs_no));
  p_cache_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(cache_o));
  p_pd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(pd_o));
  p_held_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);
  p_one_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_o, err_o, busy_o}) <= 1);
  p_quick_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || busy_o) |-> $past(req_valid_i && req_ready_o));
endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(
  .NUM_CH(NUM_CH), .RES(RES), .HALF_DIV(HALF_DIV)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .busy_o     (busy_o),
  .pd_o       (pd_o),
  .cache_o    (cache_o),
  .sclk_o     (sclk_o),
  .cs_no      (cs_no)
);

// File: tb/sim_dac_cmd_ctrl.sv
module sim_dac_cmd_ctrl;
  localparam int NUM_CH   = 4;
  localparam int RES      = 10;
  localparam int HALF_DIV = 2;
  localparam int SH       = 12 - RES;

  logic                  clk, rst_n;
  logic                  req_valid, req_ready;
  logic [1:0]            req_op, req_ch;
  logic [11:0]           req_val;
  logic                  done, err, busy, pd;
  logic [NUM_CH*RES-1:0] cache;
  logic                  sclk, cs_n, mosi;

  int total = 0, bad = 0;
  bit finished = 0;

  dac_cmd_ctrl #(.NUM_CH(NUM_CH), .RES(RES), .HALF_DIV(HALF_DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_ch_i(req_ch), .req_val_i(req_val),
    .done_o(done), .err_o(err), .busy_o(busy), .pd_o(pd), .cache_o(cache),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // serial capture
  logic [15:0] shreg = '0, last_frame = '0;
  int nbits = 0, last_bits = 0, frame_cnt = 0;
  always @(posedge sclk) if (rst_n && !cs_n) begin
    shreg = {shreg[14:0], mosi};
    nbits++;
  end
  always @(posedge cs_n) if (rst_n) begin
    last_frame = shreg;
    last_bits  = nbits;
    nbits      = 0;
    frame_cnt++;
  end

  // chip-select run lengths
  int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n) begin
      if (cs_prev) begin last_hi = hi_run; hi_run = 0; end
      lo_run++;
    end else begin
      if (!cs_prev) begin last_lo = lo_run; lo_run = 0; end
      hi_run++;
    end
    cs_prev = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns 1 done, 2 err, 3 busy, 0 none
  task automatic do_req(input logic [1:0] op, input logic [1:0] ch, input logic [11:0] v,
                        output int rsp, output bit held);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_ch = ch; req_val = v; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    held = 1'b0;
    rsp = 0;
    for (int i = 0; i < 1000; i++) begin
      if (done) begin rsp = 1; break; end
      if (err)  begin rsp = 2; break; end
      if (busy) begin rsp = 3; break; end
      if (!req_ready) held = 1'b1;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] fr(input logic [1:0] a, input logic [1:0] o, input logic [RES-1:0] v);
    return {a, o, v, {SH{1'b0}}};
  endfunction

  function automatic int ch_val(input int c);
    return int'(cache[c*RES +: RES]);
  endfunction

  // request expecting a frame
  task automatic req_frame(input logic [1:0] op, input logic [1:0] ch, input logic [11:0] v,
                           input logic [15:0] exp, input string tag);
    int rsp, f0;
    bit held;
    f0 = frame_cnt;
    do_req(op, ch, v, rsp, held);
    chk(rsp == 1, {tag, " response"}, rsp, 1);
    chk(frame_cnt == f0 + 1, {tag, " frame count"}, frame_cnt - f0, 1);
    chk(last_frame == exp, {tag, " frame"}, last_frame, exp);
    chk(last_bits == 16, "R1 bit count", last_bits, 16);
    chk(held, "R11 ready low during frame", held, 1);
  endtask

  // request expecting no frame
  task automatic req_quiet(input logic [1:0] op, input logic [1:0] ch, input logic [11:0] v,
                           input int exp_rsp, input string tag);
    int rsp, f0;
    bit held;
    f0 = frame_cnt;
    do_req(op, ch, v, rsp, held);
    chk(rsp == exp_rsp, {tag, " response"}, rsp, exp_rsp);
    chk(frame_cnt == f0, {tag, " no frame"}, frame_cnt - f0, 0);
  endtask

  task automatic t_reset;
    chk(cs_n === 1'b1 && sclk === 1'b0, "R3 reset lines", {cs_n, sclk}, 2);
    chk(req_ready === 1'b0, "R3 ready low in reset", req_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 1000 && !req_ready; i++) @(negedge clk);
    chk(frame_cnt == 1, "R3 one boot frame", frame_cnt, 1);
    chk(last_frame == 16'h2000, "R3 boot frame", last_frame, 16'h2000);
    chk(last_bits == 16, "R1 boot bits", last_bits, 16);
    chk(pd == 1'b0 && cache == '0, "R3 state after boot", int'(pd), 0);
  endtask

  task automatic t_write;
    req_frame(2'd0, 2'd1, 12'h155, fr(2'd1, 2'b01, 10'h155), "R7 write ch1");
    chk(ch_val(1) == 'h155, "R7 cache ch1", ch_val(1), 'h155);
    chk(last_lo == 32 * HALF_DIV, "R12 cs low length", last_lo, 32 * HALF_DIV);
    req_frame(2'd0, 2'd3, 12'h3FF, 16'hDFFC, "R2 write ch3 full scale");
    chk(last_hi >= 2 * HALF_DIV, "R12 cs high gap", last_hi, 2 * HALF_DIV);
    chk(ch_val(3) == 'h3FF, "R7 cache ch3", ch_val(3), 'h3FF);
    req_frame(2'd0, 2'd0, 12'h02A, 16'h10A8, "R2 write ch0");
  endtask

  task automatic t_redundant_range;
    req_quiet(2'd0, 2'd1, 12'h155, 1, "R5 same value");
    req_quiet(2'd0, 2'd0, 12'h400, 2, "R4 value too large");
    chk(ch_val(0) == 'h2A, "R4 cache kept", ch_val(0), 'h2A);
    req_quiet(2'd3, 2'd0, 12'h001, 2, "R4 reserved op");
  endtask

  task automatic t_sleep;
    req_frame(2'd1, 2'd0, 12'h001, 16'h7000, "R8 sleep mode0");
    chk(pd == 1'b1, "R8 pd set", pd, 1);
    req_quiet(2'd1, 2'd0, 12'h001, 1, "R8 sleep again");
    req_quiet(2'd0, 2'd2, 12'h005, 3, "R6 write asleep");
    chk(ch_val(2) == 0, "R6 cache ch2 kept", ch_val(2), 0);
    req_quiet(2'd0, 2'd1, 12'h155, 1, "R5 same value asleep");
    req_frame(2'd2, 2'd0, 12'h002, 16'hF000, "R10 term asleep");
    req_quiet(2'd2, 2'd0, 12'h002, 1, "R10 same term");
    req_quiet(2'd2, 2'd0, 12'h003, 2, "R10 bad term");
  endtask

  task automatic t_wake;
    req_frame(2'd1, 2'd0, 12'h000, 16'h10A8, "R9 wake");
    chk(pd == 1'b0, "R9 pd clear", pd, 0);
    req_quiet(2'd2, 2'd0, 12'h001, 1, "R10 term awake recorded");
    req_frame(2'd1, 2'd0, 12'h001, 16'hB000, "R10 recorded term in sleep");
    req_frame(2'd1, 2'd0, 12'h000, 16'h10A8, "R9 wake again");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_ch = '0; req_val = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_redundant_range();
    t_sleep();
    t_wake();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule